// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Controller

This block sits between a 32-bit processor bus and two banks of 32-bit DRAM. Doublewords are interleaved across the banks on address bit 2. Each accepted request is split into a bank, a row and a column. The controller drives one active-low row strobe per bank, four active-low column strobes per bank (one per byte lane), and a shared multiplexed DRAM address bus. It pulses a ready signal once the data phase completes.

A request that is accepted with no wait takes three clocks: row, column select, then data. A bank whose row strobe has just been released must precharge before it is opened again. As a result, alternating banks back-to-back is cheaper than hitting the same bank twice. An address-pipelining input lets the next request be presented during the current ready clock. This saves a clock only when the next access goes to the other bank.

A free-running refresh timer requests a column-before-row refresh of both banks. The refresh is granted only between bus cycles, and it can stall a pending access for a bounded number of clocks.

Top module: `dual_bank_dram_ctrl`

## Requirements
- R1: `addr_i[2]` = 0 selects bank 0: `ras_no[0]`, with column strobes on `cas_no[3:0]`. `addr_i[2]` = 1 selects bank 1: `ras_no[1]`, with column strobes on `cas_no[7:4]`. Only the selected bank's row strobe is low during an access.
- R2: An accepted access drives its row strobe low for three consecutive clocks. In the first clock `ma_o` carries the row. In the second clock `ma_o` switches to the column. In the third clock the column strobes fall and `rdy_o` is high; `rdy_o` is high for that single clock only.
- R3: In the data clock, the active bank's four column strobes equal `be_ni` as captured at acceptance (bit n drives byte lane n). The other bank's column strobes stay high.
- R4: Outside a refresh, at most one row strobe is low at any time.
- R5: A bus cycle starts at the first clock of the request. For a pipelined request, it starts at the first clock after the previous ready. Wait states are the number of clocks from the start of the bus cycle through the ready clock, minus 3. With no refresh in the way, a pipelined access to the other bank has 0 wait states, and a non-pipelined or idle-started access has 1.
- R6: After a bank's row strobe rises, it stays high for at least `TRP_CYC` clocks. A back-to-back access to the same bank therefore waits for precharge. With default parameters this costs 1 wait state, whether or not the access is pipelined.
- R7: Once every `RF_PERIOD` clocks, a refresh is requested. It is granted only while the bus is idle and both banks are precharged. All eight column strobes go low one clock before both row strobes go low. Both row strobes then stay low for `RF_RAS_CYC` clocks.
- R8: `rdy_o` is never high while a refresh owns the DRAM. A request that arrives in the first refresh clock is held and completes with 3 wait states under default parameters.
- R9: When a refresh delays an access, its wait states stay at 4 or fewer if the access goes to the other bank or starts from idle. They stay at 8 or fewer if it is a same-bank back-to-back access (default parameters).
- R10: During and right after reset, all row and column strobes are high and `rdy_o` is low.
- R11: The address fields are: column = `addr_i[COL_W+2:3]` and row = `addr_i[ROW_W+COL_W+2:COL_W+3]`. Each field is zero-extended onto `ma_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready |
| pipe_i | input | 1 | High in the ready clock when `req_i`/`addr_i` already carry the next access |
| addr_i | input | ROW_W+COL_W+1 | Doubleword address, bits [ROW_W+COL_W+2:2] |
| be_ni | input | 4 | Active-low byte enables |
| rdy_o | output | 1 | One-clock ready at the end of the data phase |
| ras_no | output | 2 | Active-low row strobes, one per bank |
| cas_no | output | 8 | Active-low column strobes, four per bank |
| ma_o | output | max(ROW_W,COL_W) | Multiplexed DRAM row/column address |

## Verification
The assertions assume the processor-side protocol. `req_i`, `addr_i` and `be_ni` stay stable from the clock a request is raised until the clock in which `rdy_o` is seen. `pipe_i` is raised only during a ready clock, and only together with the next request. The stimulus drives every input at the falling edge and follows this discipline. It drops `req_i` in the ready clock unless it pipelines the next access, and it releases `pipe_i` after one clock. Timing is checked only under default parameters, where the wait counts and caps are fixed numbers. Refresh collisions are left to fall where the free-running timer puts them, and any access that sees a refresh is judged against the caps alone.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned LANES     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DATA,
    ST_RF_CAS,
    ST_RF_RAS
  } dbd_state_e;
endpackage

// File: rtl/dbd_refresh_timer.sv
module dbd_refresh_timer #(
  parameter int unsigned RF_PERIOD = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic pend_o
);
  localparam int unsigned W = (RF_PERIOD > 2) ? $clog2(RF_PERIOD) : 1;
  localparam logic [W-1:0] RELOAD = W'(RF_PERIOD - 1);

  logic [W-1:0] cnt_q;
  logic         expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RELOAD;
      pend_o <= 1'b0;
    end else begin
      cnt_q  <= expire ? RELOAD : cnt_q - 1'b1;
      pend_o <= expire | (pend_o & ~grant_i);
    end
  end

  p_grant_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> pend_o);
endmodule

// File: rtl/dbd_precharge.sv
module dbd_precharge #(
  parameter int unsigned TRP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ready_o
);
  localparam int unsigned W = $clog2(TRP_CYC + 1);
  localparam logic [W-1:0] LOAD = W'(TRP_CYC - 1);
  localparam logic [W-1:0] FULL = W'(TRP_CYC);

  logic [W-1:0] cnt_q;
  logic [W-1:0] hi_cnt_q;

  // cnt_q holds the remaining precharge clocks after the strobe rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (busy_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = !busy_i && (cnt_q == '0);

  // clocks spent with the strobe high, saturating; used by the check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt_q <= FULL;
    else if (busy_i)             hi_cnt_q <= '0;
    else if (hi_cnt_q != FULL)   hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_trp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (hi_cnt_q >= FULL));
endmodule

// File: rtl/dual_bank_dram_ctrl.sv
module dual_bank_dram_ctrl
  import dbd_pkg::*;
#(
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned TRP_CYC    = 1,
  parameter int unsigned RF_RAS_CYC = 1,
  parameter int unsigned RF_PERIOD  = 64
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    req_i,
  input  logic                                    pipe_i,
  input  logic [ROW_W+COL_W+2:2]                  addr_i,
  input  logic [LANES-1:0]                        be_ni,
  output logic                                    rdy_o,
  output logic [NUM_BANKS-1:0]                    ras_no,
  output logic [NUM_BANKS*LANES-1:0]              cas_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ma_o
);
  localparam int unsigned MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned RFC_W = $clog2(RF_RAS_CYC + 1);
  localparam logic [RFC_W-1:0] RFC_LOAD = RFC_W'(RF_RAS_CYC - 1);

  dbd_state_e           state_q, state_d;
  logic                 bank_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic [LANES-1:0]     be_q;
  logic [RFC_W-1:0]     rf_cnt_q;
  logic [NUM_BANKS-1:0] pre_rdy;
  logic [NUM_BANKS-1:0] bank_busy;
  logic                 rf_pend, rf_grant, take, in_bank;
  logic                 access_on, rf_on, col_phase;

  assign in_bank  = addr_i[2];
  assign rf_grant = (state_q == ST_IDLE) && rf_pend && (&pre_rdy);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rf_grant) begin
          state_d = ST_RF_CAS;
        end else if (req_i && pre_rdy[in_bank]) begin
          take    = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_DATA;
      ST_DATA: begin
        // pipelined next request may start here; refresh forces an idle gap
        if (!rf_pend && pipe_i && req_i && pre_rdy[in_bank]) begin
          take    = 1'b1;
          state_d = ST_ROW;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RF_CAS: state_d = ST_RF_RAS;
      ST_RF_RAS: if (rf_cnt_q == '0) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bank_q   <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      be_q     <= '1;
      rf_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        bank_q <= addr_i[2];
        col_q  <= addr_i[COL_W+2:3];
        row_q  <= addr_i[ROW_W+COL_W+2:COL_W+3];
        be_q   <= be_ni;
      end
      if (state_q == ST_RF_CAS)                         rf_cnt_q <= RFC_LOAD;
      else if (state_q == ST_RF_RAS && rf_cnt_q != '0)  rf_cnt_q <= rf_cnt_q - 1'b1;
    end
  end

  assign access_on = state_q inside {ST_ROW, ST_COL, ST_DATA};
  assign rf_on     = state_q inside {ST_RF_CAS, ST_RF_RAS};
  assign col_phase = state_q inside {ST_COL, ST_DATA};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_busy[b] = (access_on && bank_q == 1'(b)) || (state_q == ST_RF_RAS);
    assign ras_no[b]    = ~bank_busy[b];
    assign cas_no[b*LANES +: LANES] =
      (state_q == ST_DATA && bank_q == 1'(b)) ? be_q :
      (rf_on ? '0 : '1);

    dbd_precharge #(.TRP_CYC(TRP_CYC)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .busy_i  (bank_busy[b]),
      .ready_o (pre_rdy[b])
    );
  end

  dbd_refresh_timer #(.RF_PERIOD(RF_PERIOD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (rf_grant),
    .pend_o  (rf_pend)
  );

  assign rdy_o = (state_q == ST_DATA);
  assign ma_o  = col_phase ? MA_W'(col_q) : MA_W'(row_q);

  p_ras_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_on |-> ($countones(~ras_no) <= 1));

  p_rdy_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  p_ma_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> ($stable(ma_o) && $stable(ras_no)));

  p_rdy_no_rf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (ras_no != '0));

  p_lane_b0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !ras_no[0]) |-> (&cas_no[2*LANES-1:LANES]));

  p_lane_b1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !ras_no[1]) |-> (&cas_no[LANES-1:0]));

  p_cbr_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_no == '0) |-> ($past(cas_no) == '0));
endmodule

// File: tb/dual_bank_dram_ctrl_tb_top.sv
module dual_bank_dram_ctrl_tb_top;
  localparam int RF_PERIOD = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        pipe_i = 1'b0;
  logic [18:2] addr_i = '0;
  logic [3:0]  be_ni = '1;
  logic        rdy_o;
  logic [1:0]  ras_no;
  logic [7:0]  cas_no;
  logic [7:0]  ma_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int prev_bank = -1;

  always #10 clk = ~clk;

  dual_bank_dram_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req_i), .pipe_i (pipe_i),
    .addr_i (addr_i), .be_ni (be_ni), .rdy_o (rdy_o),
    .ras_no (ras_no), .cas_no (cas_no), .ma_o (ma_o)
  );

  // {row, col, bank, be_n, pipe, expected waits}
  localparam logic [25:0] VEC [8] = '{
    {8'h12, 8'h34, 1'b0, 4'b0000, 1'b0, 4'd1},
    {8'hA5, 8'h5A, 1'b1, 4'b1110, 1'b1, 4'd0},
    {8'hFF, 8'h00, 1'b0, 4'b0111, 1'b1, 4'd0},
    {8'h00, 8'hFF, 1'b0, 4'b1010, 1'b1, 4'd1},
    {8'h3C, 8'hC3, 1'b0, 4'b0101, 1'b0, 4'd1},
    {8'h81, 8'h18, 1'b1, 4'b1100, 1'b0, 4'd1},
    {8'h7E, 8'hE7, 1'b1, 4'b0011, 1'b1, 4'd1},
    {8'h01, 8'h80, 1'b0, 4'b1011, 1'b1, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_acc(input logic [7:0] row, input logic [7:0] col,
                         input logic bank, input logic [3:0] be, input bit pipe,
                         output int waits, output bit rf);
    logic [1:0] hr [3];
    logic [7:0] hm [3];
    bit got, excl_ok, rdy_rf_ok;
    int n;
    addr_i = {row, col, bank};
    be_ni  = be;
    req_i  = 1'b1;
    pipe_i = pipe;
    n = pipe ? 0 : 1;
    rf = (cas_no == '0);
    got = 1'b0;
    excl_ok = 1'b1;
    rdy_rf_ok = 1'b1;
    for (int k = 0; k < 3; k++) begin hr[k] = 2'b11; hm[k] = '0; end
    while (!got) begin
      @(negedge clk);
      pipe_i = 1'b0;
      n++;
      hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = ras_no;
      hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = ma_o;
      if (cas_no == '0) rf = 1'b1;
      if ($countones(~ras_no) > 1 && cas_no != '0) excl_ok = 1'b0;
      if (rdy_o && ras_no == 2'b00) rdy_rf_ok = 1'b0;
      if (rdy_o) got = 1'b1;
      if (n > 60) begin
        chk(1'b0, "R2", "access never ready", n, 0);
        got = 1'b1;
      end
    end
    req_i = 1'b0;
    waits = n - 3;
    chk(excl_ok, "R4", "two row strobes low outside refresh", 0, 1);
    chk(rdy_rf_ok, "R8", "ready during refresh", 0, 1);
    chk(ras_no == (bank ? 2'b01 : 2'b10), "R1", "row strobe of bank", ras_no,
        bank ? 2'b01 : 2'b10);
    chk(hr[1] == ras_no && hr[2] == ras_no, "R2", "row strobe held three clocks",
        {hr[2], hr[1]}, {ras_no, ras_no});
    chk(hm[2] == row, "R11", "row on ma_o", hm[2], row);
    chk(hm[1] == col && hm[0] == col, "R2", "column on ma_o", {hm[1], hm[0]}, {col, col});
    chk(cas_no == (bank ? {be, 4'hF} : {4'hF, be}), "R3", "column strobes", cas_no,
        bank ? {be, 4'hF} : {4'hF, be});
  endtask

  task automatic judge(input int waits, input bit rf, input int exp, input bit same);
    if (!rf) chk(waits == exp, same ? "R6" : "R5", "wait states", waits, exp);
    else     chk(waits <= (same ? 8 : 4), "R9", "wait cap with refresh", waits, same ? 8 : 4);
  endtask

  task automatic wait_rf(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      @(negedge clk);
      if (cas_no == '0 && ras_no == 2'b11) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    bit rf, seen, same, pipe, bank;
    logic [25:0] v;

    repeat (3) @(negedge clk);
    chk(ras_no == 2'b11 && cas_no == 8'hFF && !rdy_o, "R10", "strobes in reset",
        {rdy_o, ras_no, cas_no}, 11'h3FF);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ras_no == 2'b11 && cas_no == 8'hFF && !rdy_o, "R10", "strobes after reset",
        {rdy_o, ras_no, cas_no}, 11'h3FF);

    // vector table: mixed banks, lanes and pipelining
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      if (!v[4]) @(negedge clk);
      same = (prev_bank == int'(v[9]));
      run_acc(v[25:18], v[17:10], v[9], v[8:5], v[4], w, rf);
      judge(w, rf, int'(v[3:0]), same);
      prev_bank = int'(v[9]);
    end
    repeat (4) @(negedge clk);
    prev_bank = -1;

    // long back-to-back run that collides with refresh
    for (int i = 0; i < 90; i++) begin
      bank = 1'(((i * 7) / 3) % 2);
      pipe = (i % 4 != 0);
      if (!pipe) @(negedge clk);
      same = (prev_bank == int'(bank));
      run_acc(8'(i * 29), 8'(i * 53 + 7), bank, 4'((i * 37) % 16), pipe, w, rf);
      judge(w, rf, (pipe && !same) ? 0 : 1, same);
      prev_bank = int'(bank);
    end
    repeat (4) @(negedge clk);
    prev_bank = -1;

    // refresh shape and period with an idle bus
    wait_rf(seen);
    chk(seen, "R7", "refresh column-first clock seen", seen, 1);
    @(negedge clk);
    chk(ras_no == 2'b00 && cas_no == 8'h00, "R7", "both row strobes in refresh",
        {ras_no, cas_no}, 0);
    @(negedge clk);
    chk(ras_no == 2'b11 && cas_no == 8'hFF, "R7", "refresh ends after one row clock",
        {ras_no, cas_no}, 10'h3FF);
    begin
      int k;
      k = 2;
      seen = 1'b0;
      while (!seen && k < 300) begin
        @(negedge clk);
        k++;
        if (cas_no == '0 && ras_no == 2'b11) seen = 1'b1;
      end
      chk(k == RF_PERIOD, "R7", "refresh period", k, RF_PERIOD);
    end

    // request raised in the first refresh clock is held
    wait_rf(seen);
    chk(seen, "R8", "second refresh seen", seen, 1);
    run_acc(8'h5D, 8'h2B, 1'b1, 4'b0110, 1'b0, w, rf);
    chk(w == 3, "R8", "wait states behind refresh", w, 3);
    chk(w <= 4, "R9", "cap behind refresh", w, 4);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule